// File: doc/BRIEF.md
# Multiplexed pin interrupt controller

The block watches a set of general-purpose pins and folds them into one interrupt line. The pins arrive as several 16-pin ports. Each port has a lower 8-pin half and an upper 8-pin half. A routing register picks, for each of the four bytes of a 32-lane sense vector, which port's half drives that byte. Even bytes take a lower half and odd bytes take an upper half.

Each lane passes through an optional inversion and then a rising-only detector. The detector can be edge-sensitive or level-sensitive. A hit sets a sticky request bit. A per-lane mask decides whether a pending request reaches the combined interrupt output.

Software controls the block through eight 32-bit word registers. Invert, edge-select and mask are each changed through a pair of write-1-to-set and write-1-to-clear addresses. Pending requests are cleared by writing 1 to them. Falling-edge or active-low sensing is obtained by setting the lane's invert bit.

Top module: `pinint_ctrl`

## Requirements
- R1: Port p occupies pins_i[16p+15:16p]. Routing register byte k (bits 8k+7:8k) holds a port index. Lane byte k is driven by that port's bits 7:0 when k is even and by its bits 15:8 when k is odd. An index of NUM_PORTS or more drives that byte with zeros.
- R2: A lane value is the routed pin XOR the lane's invert bit. A lane only raises a request when this value is 1 (level lanes) or goes from 0 to 1 (edge lanes). With the invert bit set, a rising pin on an edge lane raises nothing and a falling pin raises a request.
- R3: An edge-select bit of 1 makes the lane edge-sensitive, and its request stays set after the pin returns. An edge-select bit of 0 makes the lane level-sensitive.
- R4: Register word addresses are 0 routing (read/write), 1 mask set, 2 mask clear, 3 request, 4 invert set, 5 invert clear, 6 edge set and 7 edge clear. Addresses 1/2, 4/5 and 6/7 read back the current mask, invert and edge vectors. On a set or clear address, a 1 bit changes only that bit and a 0 bit leaves it alone.
- R5: Writing 1 to a bit of address 3 clears that request at the write edge, and the clear wins over a hit in the same cycle. A level lane whose value is still 1 sets its request again on the next clock. An edge lane held high does not set it again.
- R6: Requests of lanes 0-15 and lanes 16-31 are independent. A clear aimed at one half leaves the other half's pending bits unchanged.
- R7: irq_o is 1 exactly when some lane has both its request bit and its mask bit at 1. With the mask at zero, irq_o stays 0 whatever is pending.
- R8: Pins pass through a two-flop synchronizer. A pin change driven before clock edge N shows in the request register after edge N+2 and not after edge N+1.
- R9: A synchronous active-low reset clears routing, mask, invert, edge and request to zero. All eight addresses then read 0 and irq_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pins_i | input | NUM_PORTS*16 | Asynchronous pin inputs, port p in bits 16p+15:16p |
| reg_addr_i | input | 3 | Register word address |
| reg_wr_i | input | 1 | Write strobe, applied at the clock edge |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i, combinational |
| irq_o | output | 1 | Combined interrupt |

## Verification
Register writes take effect at the clock edge they are presented on. Read data and irq_o follow state combinationally, so the bench reads at the falling edge right after a write. A pin change needs three rising edges to reach the request register: two synchronizer stages and the request flop. The latency check samples one edge early to see 0 and at the third edge to see 1. Table vectors and the level re-assert case allow at least that many edges before reading, except where the exact edge is the point of the check.

// File: rtl/pinint_pkg.sv
// Shared constants and register address map for the pin interrupt controller.
// Assumes a 32-lane sense vector built from four 8-bit bytes.
package pinint_pkg;
    localparam int LANES  = 32;
    localparam int BYTES  = LANES / 8;
    localparam int HALF_W = 8;
    localparam int PORT_W = 2 * HALF_W;

    typedef enum logic [2:0] {
        REG_ROUTE    = 3'd0,
        REG_MASK_SET = 3'd1,
        REG_MASK_CLR = 3'd2,
        REG_REQ      = 3'd3,
        REG_INV_SET  = 3'd4,
        REG_INV_CLR  = 3'd5,
        REG_EDGE_SET = 3'd6,
        REG_EDGE_CLR = 3'd7
    } reg_sel_e;
endpackage

// File: rtl/pinint_sync.sv
// Two-flop synchronizer for a vector of asynchronous pin inputs.
// Assumes each bit is an independent level; no bus coherency is implied.
module pinint_sync #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    // Shift pins through two capture stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= d_i;
            stage2_q <= stage1_q;
        end
    end

    assign q_o = stage2_q;
endmodule

// File: rtl/pinint_route.sv
// Byte-lane router: each byte of the 32-lane vector takes one port half.
// Even bytes take a lower half and odd bytes an upper half, as picked by
// the port index held in the matching byte of the routing register.
// Assumes an index at or above NUM_PORTS selects nothing (zeros).
module pinint_route
    import pinint_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    localparam int PIN_W = NUM_PORTS * PORT_W
) (
    input  logic [PIN_W-1:0] pins_i,
    input  logic [LANES-1:0] route_i,
    output logic [LANES-1:0] lanes_o
);
    for (genvar k = 0; k < BYTES; k++) begin : g_byte
        localparam int HALF_OFS = (k % 2) * HALF_W;
        logic [HALF_W-1:0] byte_v;

        // Pick the half of the indexed port for this byte.
        always_comb begin
            byte_v = '0;
            for (int p = 0; p < NUM_PORTS; p++) begin
                if (route_i[8*k +: 8] == 8'(p))
                    byte_v = pins_i[PORT_W*p + HALF_OFS +: HALF_W];
            end
        end

        assign lanes_o[8*k +: 8] = byte_v;
    end
endmodule

// File: rtl/pinint_sense.sv
// Per-lane sensing and sticky request register.
// Lane value = raw XOR invert; level lanes hit while 1, edge lanes on 0->1.
// A write-1 clear wins over a hit in the same cycle.
module pinint_sense
    import pinint_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] raw_i,
    input  logic [LANES-1:0] inv_i,
    input  logic [LANES-1:0] edge_i,
    input  logic [LANES-1:0] clr_i,
    output logic [LANES-1:0] req_o
);
    logic [LANES-1:0] lane_v;
    logic [LANES-1:0] lane_q;
    logic [LANES-1:0] hit;
    logic [LANES-1:0] req_q;

    assign lane_v = raw_i ^ inv_i;
    assign hit    = (edge_i & lane_v & ~lane_q) | (~edge_i & lane_v);

    // Keep last lane value for edge detection and update requests.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lane_q <= '0;
            req_q  <= '0;
        end else begin
            lane_q <= lane_v;
            req_q  <= (req_q | hit) & ~clr_i;
        end
    end

    assign req_o = req_q;

    // R5: a cleared bit reads 0 right after the clear edge.
    a_r5_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i != '0) |=> ((req_o & $past(clr_i)) == '0));

    // R3: an edge lane's request never drops without a clear.
    a_r3_edge_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(req_o) & $past(edge_i) & ~$past(clr_i) & ~req_o) == '0));

    // R2: a level lane with value 1 is pending on the next cycle unless cleared.
    a_r2_level_sets: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((~$past(edge_i) & $past(lane_v) & ~$past(clr_i) & ~req_o) == '0));
endmodule

// File: rtl/pinint_ctrl.sv
// Multiplexed pin interrupt controller top: register file, synchronizer,
// byte-lane router and sense/request logic, with one combined interrupt.
// Assumes a single-cycle write strobe and a combinational read path.
module pinint_ctrl
    import pinint_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    localparam int PIN_W = NUM_PORTS * PORT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PIN_W-1:0] pins_i,
    input  logic [2:0]       reg_addr_i,
    input  logic             reg_wr_i,
    input  logic [31:0]      reg_wdata_i,
    output logic [31:0]      reg_rdata_o,
    output logic             irq_o
);
    logic [PIN_W-1:0] pins_s;
    logic [LANES-1:0] lanes_raw;
    logic [LANES-1:0] route_q, mask_q, inv_q, edge_q;
    logic [LANES-1:0] req;
    logic [LANES-1:0] req_clr;
    reg_sel_e         sel;

    assign sel = reg_sel_e'(reg_addr_i);

    pinint_sync #(.W(PIN_W)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (pins_i),
        .q_o   (pins_s)
    );

    pinint_route #(.NUM_PORTS(NUM_PORTS)) route_i (
        .pins_i  (pins_s),
        .route_i (route_q),
        .lanes_o (lanes_raw)
    );

    pinint_sense sense_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (lanes_raw),
        .inv_i  (inv_q),
        .edge_i (edge_q),
        .clr_i  (req_clr),
        .req_o  (req)
    );

    // Write-1-to-clear vector for the request register.
    assign req_clr = (reg_wr_i && sel == REG_REQ) ? reg_wdata_i : '0;

    // Control register updates via plain write or set/clear pairs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            route_q <= '0;
            mask_q  <= '0;
            inv_q   <= '0;
            edge_q  <= '0;
        end else if (reg_wr_i) begin
            case (sel)
                REG_ROUTE:    route_q <= reg_wdata_i;
                REG_MASK_SET: mask_q  <= mask_q | reg_wdata_i;
                REG_MASK_CLR: mask_q  <= mask_q & ~reg_wdata_i;
                REG_INV_SET:  inv_q   <= inv_q | reg_wdata_i;
                REG_INV_CLR:  inv_q   <= inv_q & ~reg_wdata_i;
                REG_EDGE_SET: edge_q  <= edge_q | reg_wdata_i;
                REG_EDGE_CLR: edge_q  <= edge_q & ~reg_wdata_i;
                default:      ;
            endcase
        end
    end

    // Read mux: set/clear pairs both return the current vector.
    always_comb begin
        case (sel)
            REG_ROUTE:                  reg_rdata_o = route_q;
            REG_MASK_SET, REG_MASK_CLR: reg_rdata_o = mask_q;
            REG_REQ:                    reg_rdata_o = req;
            REG_INV_SET, REG_INV_CLR:   reg_rdata_o = inv_q;
            default:                    reg_rdata_o = edge_q;
        endcase
    end

    assign irq_o = |(req & mask_q);

    // R7: nothing masked in means no interrupt.
    a_r7_quiet_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |-> !irq_o);

    // R4: set address turns on every written 1 bit.
    a_r4_mask_set: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_i && sel == REG_MASK_SET) |=> ((mask_q & $past(reg_wdata_i)) == $past(reg_wdata_i)));

    // R4: clear address turns off every written 1 bit.
    a_r4_mask_clr: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_i && sel == REG_MASK_CLR) |=> ((mask_q & $past(reg_wdata_i)) == '0));
endmodule

// File: tb/pinint_ctrl_tb.sv
// Self-checking bench: table-driven routing/sensing vectors, then directed tests.
module pinint_ctrl_tb_top;
    localparam int NP = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [63:0]   pins = '0;
    logic [2:0]    addr = '0;
    logic          wr = 1'b0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic          irq;
    int            errors = 0;
    int            checks = 0;
    logic [31:0]   v;

    always #5 clk = ~clk;

    pinint_ctrl #(.NUM_PORTS(NP)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .pins_i      (pins),
        .reg_addr_i  (addr),
        .reg_wr_i    (wr),
        .reg_wdata_i (wdata),
        .reg_rdata_o (rdata),
        .irq_o       (irq)
    );

    // Vector: route, invert, edge, pins (port3..port0), expected request.
    localparam logic [191:0] VEC [6] = '{
        {32'h00000000, 32'h00000000, 32'h00000000, 64'h0000_0000_0000_00A5, 32'h00A500A5},
        {32'h03020100, 32'h00000000, 32'hFFFFFFFF, 64'h4400_0033_2200_0011, 32'h44332211},
        {32'h00000000, 32'h000000FF, 32'h00000000, 64'h0000_0000_0000_0000, 32'h000000FF},
        {32'h00000000, 32'h000000FF, 32'hFFFFFFFF, 64'h0000_0000_0000_000F, 32'h000F0000},
        {32'h00000303, 32'h00000000, 32'h0000FFFF, 64'hABCD_0000_0000_1234, 32'h1234ABCD},
        {32'h04010203, 32'h00000000, 32'h00000000, 64'h0077_8800_0099_6600, 32'h00998877}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [2:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R9: reset state of every address and of the interrupt.
        for (int a = 0; a < 8; a++) begin
            rd_reg(3'(a), v);
            chk("R9 reset read", v, 32'h0);
        end
        chk("R9 reset irq", {31'h0, irq}, 32'h0);

        // R1 R2 R3 R7: table of routing and sensing vectors.
        for (int i = 0; i < 6; i++) begin
            pins = '0;
            wr_reg(3'd0, VEC[i][191:160]);
            wr_reg(3'd5, 32'hFFFFFFFF);
            wr_reg(3'd4, VEC[i][159:128]);
            wr_reg(3'd7, 32'hFFFFFFFF);
            wr_reg(3'd6, VEC[i][127:96]);
            wait_cyc(5);
            wr_reg(3'd3, 32'hFFFFFFFF);
            @(negedge clk);
            pins = VEC[i][95:32];
            wait_cyc(4);
            rd_reg(3'd3, v);
            chk("R1 R2 R3 vector request", v, VEC[i][31:0]);
            chk("R7 masked-off irq", {31'h0, irq}, 32'h0);
            rd_reg(3'd5, v);
            chk("R4 invert readback", v, VEC[i][159:128]);
        end

        // R4: set/clear pairs, zero bits have no effect.
        wr_reg(3'd1, 32'h1);
        wr_reg(3'd1, 32'h2);
        rd_reg(3'd1, v);
        chk("R4 mask set", v, 32'h3);
        wr_reg(3'd2, 32'h1);
        rd_reg(3'd2, v);
        chk("R4 mask clear", v, 32'h2);
        wr_reg(3'd2, 32'h0);
        rd_reg(3'd1, v);
        chk("R4 zero write ignored", v, 32'h2);
        wr_reg(3'd2, 32'hFFFFFFFF);

        // Setup: route port0 everywhere, all edge, no invert, clean requests.
        pins = '0;
        wr_reg(3'd0, 32'h0);
        wr_reg(3'd5, 32'hFFFFFFFF);
        wr_reg(3'd6, 32'hFFFFFFFF);
        wait_cyc(5);
        wr_reg(3'd3, 32'hFFFFFFFF);

        // R8: synchronizer latency of three edges.
        pins[0] = 1'b1;
        @(posedge clk); @(posedge clk); @(negedge clk);
        rd_reg(3'd3, v);
        chk("R8 not yet after two edges", v, 32'h0);
        @(posedge clk); @(negedge clk);
        rd_reg(3'd3, v);
        chk("R8 visible after three edges", v, 32'h00010001);

        // R3: edge request stays after pin returns.
        pins[0] = 1'b0;
        wait_cyc(5);
        rd_reg(3'd3, v);
        chk("R3 edge sticky", v, 32'h00010001);

        // R6: clearing the upper half leaves the lower half pending.
        wr_reg(3'd3, 32'hFFFF0000);
        rd_reg(3'd3, v);
        chk("R6 halves independent", v, 32'h00000001);

        // R7: interrupt follows request AND mask.
        wr_reg(3'd1, 32'h1);
        chk("R7 irq on", {31'h0, irq}, 32'h1);
        wr_reg(3'd2, 32'h1);
        chk("R7 irq off when masked", {31'h0, irq}, 32'h0);
        wr_reg(3'd1, 32'h00010000);
        chk("R7 no irq for cleared lane", {31'h0, irq}, 32'h0);
        wr_reg(3'd2, 32'hFFFFFFFF);

        // R5: level lane re-asserts next clock, edge lane does not.
        wr_reg(3'd7, 32'h1);
        pins[0] = 1'b1;
        wait_cyc(5);
        wr_reg(3'd3, 32'h00010001);
        rd_reg(3'd3, v);
        chk("R5 cleared at write edge", v & 32'h00010001, 32'h0);
        @(posedge clk); @(negedge clk);
        rd_reg(3'd3, v);
        chk("R5 level re-assert", v & 32'h00010001, 32'h00000001);
        wait_cyc(3);
        rd_reg(3'd3, v);
        chk("R5 edge lane stays clear", v & 32'h00010000, 32'h0);

        // R2: inverted edge lane ignores the pin rise and fires on its fall.
        wr_reg(3'd4, 32'h00010000);
        wait_cyc(4);
        rd_reg(3'd3, v);
        chk("R2 inverted lane quiet", v & 32'h00010000, 32'h0);
        pins[0] = 1'b0;
        wait_cyc(4);
        rd_reg(3'd3, v);
        chk("R2 inverted lane falling edge", v & 32'h00010000, 32'h00010000);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule